// File: doc/BRIEF.md
# Carry-Save Tree Multiply-Add Unit

This block forms the unsigned product of two N-bit operands and adds a 2N-bit addend in the same pass, giving a 2N-bit result `r = a*b + c` that wraps modulo 2^(2N). It is purely combinational. A host places it inside its own pipeline and registers the result wherever its timing requires.

Internally, every bit of `b` gates a copy of `a` that is shifted by that bit's position. This gives N rows, each 2N bits wide. The addend `c` joins these rows as one more row. Layers of 3:2 carry-save rows then cut the row count by roughly a third per layer, with no carry rippling inside a layer, until two vectors remain. One carry-propagate adder sums those two vectors into `r`. Because the addend is only an extra row in the tree, the accumulate costs at most one more carry-save layer and no second long adder.

Top module: `csa_mul_add`

## Requirements
- R1: `r` equals `(a*b + c) mod 2^(2N)` for every combination of inputs, with all operands unsigned.
- R2: Bit i of `b` contributes `a` shifted left by i positions when set and nothing when clear: with `b` = 0, `r` = `c`, and with only bit i of `b` set, `r` = `(a<<i) + c` mod 2^(2N).
- R3: Every carry-save layer preserves the modulo-2^(2N) sum of its rows, so patterns that produce long carry chains (alternating bits, all-ones rows) still give the exact result of R1.
- R4: The addend `c` is taken at its full 2N-bit width, including its top bit: with `a` = 0, `r` = `c` for any `c`.
- R5: Any carry out of bit 2N-1 is discarded. With `a`, `b` and `c` all ones, `r` = `(2^N-1)^2 + 2^(2N) - 1` mod 2^(2N), which is 16'hFE00 for N = 8.
- R6: The operand width N is a parameter valid from 4 to 16, and the tree depth follows from it. An instance with N = 4 obeys R1, and its all-ones case gives 8'hE0.
- R7: The block holds no state. `r` follows a change of `a`, `b` or `c` with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier; each bit gates one shifted row |
| c | input | 2N | Unsigned addend folded into the reduction tree |
| r | output | 2N | `a*b + c` modulo 2^(2N) |

## Verification
The block keeps nothing between evaluations, so a faulty internal node shows up in `r` as soon as the inputs settle. It shows only for input patterns that excite that node. A wrong gate row appears when `b` is one-hot, and a carry vector placed at the wrong weight appears when operands produce many carries. A dropped pass-through row appears as a missing addend or a missing high partial product. For that reason the directed cases walk every bit of `b`, push all-ones and alternating patterns through the tree, and check a second width, because the row-count pattern per layer changes with N.

// File: rtl/csa_mul_add_pkg.sv
package csa_mul_add_pkg;

    // Rows left after one carry-save layer: each full group of three
    // becomes two, and a remainder of one or two rows passes through.
    function automatic int next_rows(input int m);
        return (m / 3) * 2 + (m % 3);
    endfunction

    // Row count present at the input of a given layer index.
    function automatic int rows_at(input int m0, input int layer);
        int m;
        m = m0;
        for (int k = 0; k < layer; k++) begin
            m = next_rows(m);
        end
        return m;
    endfunction

    // Number of carry-save layers needed to reach two rows.
    function automatic int layer_count(input int m0);
        int m;
        int k;
        m = m0;
        k = 0;
        while (m > 2) begin
            m = next_rows(m);
            k++;
        end
        return k;
    endfunction

    // Smallest and largest supported operand widths.
    localparam int MIN_OPW = 4;
    localparam int MAX_OPW = 16;

endpackage

// File: rtl/pp_gen.sv
module pp_gen #(
    parameter int N = 8,
    parameter int W = 2 * N
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [W-1:0] pp [N]
);
    logic [W-1:0] a_wide;
    assign a_wide = W'(a);

    for (genvar i = 0; i < N; i++) begin : g_row
        assign pp[i] = b[i] ? (a_wide << i) : '0;
    end

    // R2: the gated rows together hold exactly the product
    always_comb begin
        logic [W-1:0] acc;
        acc = '0;
        for (int i = 0; i < N; i++) begin
            acc = acc + pp[i];
        end
        assert_pp_sum_R2: assert (acc == W'(W'(a) * W'(b)))
            else $error("partial rows do not sum to a*b");
    end
endmodule

// File: rtl/csa_row.sv
module csa_row #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] t
);
    logic [W-1:0] maj;

    // Independent full adders; the majority vector moves one place up.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            s[i]   = x[i] ^ y[i] ^ z[i];
            maj[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
        end
    end

    assign t = {maj[W-2:0], 1'b0};

    // R3: three rows in, two rows out, same sum modulo 2^W
    always_comb begin
        assert_csa_sum_R3: assert (W'(s + t) == W'(x + y + z))
            else $error("carry-save row changed the sum");
    end
endmodule

// File: rtl/csa_tree.sv
module csa_tree
    import csa_mul_add_pkg::*;
#(
    parameter int W    = 16,
    parameter int ROWS = 9
) (
    input  logic [W-1:0] ops [ROWS],
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);
    localparam int LAYERS = layer_count(ROWS);

    for (genvar l = 0; l <= LAYERS; l++) begin : stage
        localparam int CNT = rows_at(ROWS, l);
        logic [W-1:0] v [CNT];

        if (l == 0) begin : g_in
            for (genvar k = 0; k < CNT; k++) begin : g_cp
                assign v[k] = ops[k];
            end
        end else begin : g_red
            localparam int PREV = rows_at(ROWS, l - 1);
            localparam int GRP  = PREV / 3;
            localparam int LEFT = PREV % 3;

            for (genvar g = 0; g < GRP; g++) begin : g_csa
                csa_row #(.W(W)) u_row (
                    .x (stage[l-1].v[3*g]),
                    .y (stage[l-1].v[3*g+1]),
                    .z (stage[l-1].v[3*g+2]),
                    .s (v[2*g]),
                    .t (v[2*g+1])
                );
            end

            for (genvar k = 0; k < LEFT; k++) begin : g_pass
                assign v[2*GRP+k] = stage[l-1].v[3*GRP+k];
            end
        end
    end

    assign sum_o   = stage[LAYERS].v[0];
    assign carry_o = stage[LAYERS].v[1];

    // R3: the two surviving vectors carry the whole sum of the input rows
    always_comb begin
        logic [W-1:0] acc;
        acc = '0;
        for (int k = 0; k < ROWS; k++) begin
            acc = acc + ops[k];
        end
        assert_tree_sum_R3: assert (acc == W'(sum_o + carry_o))
            else $error("reduction tree lost part of the sum");
    end
endmodule

// File: rtl/cpa_add.sv
module cpa_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    // Final carry-propagate stage; the carry out of the top bit is dropped.
    assign s = x + y;
endmodule

// File: rtl/csa_mul_add.sv
module csa_mul_add
    import csa_mul_add_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    input  logic [2*N-1:0] c,
    output logic [2*N-1:0] r
);
    localparam int W    = 2 * N;
    localparam int ROWS = N + 1;

    logic [W-1:0] pp      [N];
    logic [W-1:0] ops     [ROWS];
    logic [W-1:0] red_sum;
    logic [W-1:0] red_cy;

    pp_gen #(.N(N), .W(W)) u_pp (
        .a  (a),
        .b  (b),
        .pp (pp)
    );

    // The addend takes the spare slot after the gated rows.
    for (genvar k = 0; k < N; k++) begin : g_ops
        assign ops[k] = pp[k];
    end
    assign ops[N] = c;

    csa_tree #(.W(W), .ROWS(ROWS)) u_tree (
        .ops     (ops),
        .sum_o   (red_sum),
        .carry_o (red_cy)
    );

    cpa_add #(.W(W)) u_cpa (
        .x (red_sum),
        .y (red_cy),
        .s (r)
    );

    initial begin
        assert_width_range_R6: assert (N >= MIN_OPW && N <= MAX_OPW)
            else $error("operand width outside supported range");
    end

    always_comb begin
        // R1: full multiply-add law at the ports
        assert_result_R1: assert (r == W'(W'(a) * W'(b) + c))
            else $error("r differs from a*b+c");
        // R4: with no product the addend appears unchanged
        if (a == '0 || b == '0) begin
            assert_addend_pass_R4: assert (r == c)
                else $error("addend not passed through");
        end
    end
endmodule

// File: tb/test_csa_mul_add.sv
module test_csa_mul_add;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int W  = 2 * N;
    localparam int N4 = 4;
    localparam int W4 = 2 * N4;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [N-1:0]   a = '0;
    logic [N-1:0]   b = '0;
    logic [W-1:0]   c = '0;
    logic [W-1:0]   r;
    logic [N4-1:0]  a4 = '0;
    logic [N4-1:0]  b4 = '0;
    logic [W4-1:0]  c4 = '0;
    logic [W4-1:0]  r4;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    csa_mul_add #(.N(N)) i_csa_mul_add (.a(a), .b(b), .c(c), .r(r));
    csa_mul_add #(.N(N4)) i_csa_mul_add_w4 (.a(a4), .b(b4), .c(c4), .r(r4));

    function automatic logic [W-1:0] model8(logic [N-1:0] x, logic [N-1:0] y, logic [W-1:0] z);
        logic [31:0] full;
        full = 32'(x) * 32'(y) + 32'(z);
        return full[W-1:0];
    endfunction

    function automatic logic [W4-1:0] model4(logic [N4-1:0] x, logic [N4-1:0] y, logic [W4-1:0] z);
        logic [31:0] full;
        full = 32'(x) * 32'(y) + 32'(z);
        return full[W4-1:0];
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive8(logic [N-1:0] x, logic [N-1:0] y, logic [W-1:0] z);
        @(negedge clk);
        a = x; b = y; c = z;
        #1;
    endtask

    task automatic t_idle();
        #1;
        check("R1 idle zero", 32'(r), 32'h0);
        check("R1 idle zero w4", 32'(r4), 32'h0);
    endtask

    task automatic t_onehot_b();
        for (int i = 0; i < N; i++) begin
            drive8(8'hB5, N'(1) << i, 16'h0103);
            check("R2 one-hot b", 32'(r), 32'(model8(8'hB5, N'(1) << i, 16'h0103)));
        end
        drive8(8'hFF, 8'h00, 16'h1234);
        check("R2 b zero", 32'(r), 32'h1234);
    endtask

    task automatic t_addend();
        drive8(8'h00, 8'hFF, 16'h8001);
        check("R4 addend top bit", 32'(r), 32'h8001);
        drive8(8'h00, 8'h5A, 16'hFFFF);
        check("R4 addend all ones", 32'(r), 32'hFFFF);
        drive8(8'h01, 8'h01, 16'h0000);
        check("R1 unit product", 32'(r), 32'h0001);
    endtask

    task automatic t_carry_chains();
        drive8(8'hAA, 8'h55, 16'h5555);
        check("R3 alternating", 32'(r), 32'(model8(8'hAA, 8'h55, 16'h5555)));
        drive8(8'h55, 8'hAA, 16'hAAAA);
        check("R3 alternating swap", 32'(r), 32'(model8(8'h55, 8'hAA, 16'hAAAA)));
        drive8(8'hFF, 8'hFF, 16'h0000);
        check("R3 all-ones zero addend", 32'(r), 32'hFE01);
        drive8(8'hFF, 8'h80, 16'h00FF);
        check("R3 top row", 32'(r), 32'(model8(8'hFF, 8'h80, 16'h00FF)));
    endtask

    task automatic t_wrap();
        drive8(8'hFF, 8'hFF, 16'hFFFF);
        check("R5 wrap all ones", 32'(r), 32'hFE00);
        drive8(8'hFF, 8'hFF, 16'h01FF);
        check("R5 wrap exact", 32'(r), 32'h0000);
    endtask

    task automatic t_random();
        for (int k = 0; k < 200; k++) begin
            logic [N-1:0] x;
            logic [N-1:0] y;
            logic [W-1:0] z;
            x = N'($urandom);
            y = N'($urandom);
            z = W'($urandom);
            drive8(x, y, z);
            check("R1 random", 32'(r), 32'(model8(x, y, z)));
        end
    endtask

    task automatic t_narrow();
        @(negedge clk);
        a4 = 4'hF; b4 = 4'hF; c4 = 8'hFF;
        #1;
        check("R6 w4 all ones", 32'(r4), 32'hE0);
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y += 5) begin
                @(negedge clk);
                a4 = N4'(x); b4 = N4'(y); c4 = W4'(x * 17 + 3);
                #1;
                check("R6 w4 sweep", 32'(r4), 32'(model4(N4'(x), N4'(y), W4'(x * 17 + 3))));
            end
        end
    endtask

    task automatic t_no_clock();
        @(posedge clk);
        #1;
        a = 8'h3C; b = 8'hC3; c = 16'h0F0F;
        #1;
        check("R7 settles between edges", 32'(r), 32'(model8(8'h3C, 8'hC3, 16'h0F0F)));
        b = 8'h00;
        #1;
        check("R7 follows change", 32'(r), 32'h0F0F);
    endtask

    initial begin
        t_idle();
        t_onehot_b();
        t_addend();
        t_carry_chains();
        t_wrap();
        t_random();
        t_narrow();
        t_no_clock();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule